// File: doc/BRIEF.md
# Telephone Ring Cadence Generator

This block drives a telephone bell with a gated ringing signal. It is fed a 100 Hz reference strobe. A divider chain turns that strobe into a 25 Hz square-wave ringing tone and a 200 ms cadence step. A step counter moves forward by one each cadence step. The counter indexes a one-bit pattern table, and the table bit decides whether the current step rings or stays silent.

The table holds two 64-step banks, and a select level picks one of them. The first bank gives a short double-ring cadence. The second gives a long single ring followed by a long pause. The ring output is high only while the tone is high and the pattern bit is set. Everything runs in one system clock domain and uses clock enables, with no derived clocks.

Top module: `ringCadenceTop`

## Requirements
- R1: After synchronous reset the tone is low and the step counter holds step 0. With bank select low, the gate output is 1 (step 0 rings) and the ring output is 0.
- R2: The tone toggles on every second 100 Hz strobe. After the n-th strobe since reset, the tone is high when floor(n/2) is odd. This gives a 4-strobe period with a 50% duty cycle.
- R3: The step counter advances once every 20 strobes, on the strobe where the tone falls for the fifth time in the step. After the n-th strobe it holds floor(n/20) mod 64.
- R4: With bank select low (table address bit 6 = 0), step s rings when s mod 16 is 0, 1, 3 or 4. All other steps are silent.
- R5: With bank select high (table address bit 6 = 1), steps 0 to 19 ring and steps 20 to 63 are silent.
- R6: A change on bank select changes the gate output in the same cycle. It does not move or reset the step counter.
- R7: The ring output equals the tone ANDed with the gate output.
- R8: After step 63 the counter returns to step 0, and the pattern repeats indefinitely.
- R9: A cycle without a strobe leaves the tone, the step counter and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickIn | input | 1 | One-cycle 100 Hz reference strobe |
| bankSel | input | 1 | Bank select: 0 for double ring, 1 for long ring |
| toneOut | output | 1 | 25 Hz ringing tone |
| gateOut | output | 1 | Current cadence pattern bit |
| ringOut | output | 1 | Tone gated by the pattern bit |

## Verification
The bench builds the block with its defaults: a base divide of 2 strobes per tone half period, 5 tone periods per step, and a 6-bit step counter. With these values one full 64-step bank lasts 1280 strobes. That is short enough for the bench to run through every step of both banks and to see the counter wrap in each. It also switches bank select in the middle of a step and inserts cycles without a strobe. This checks that the step counter keeps its place across a bank switch and holds still when no strobe arrives.

// File: rtl/ringCadencePkg.sv
package ringCadencePkg;

  // strobes from control to datapath
  typedef struct packed {
    logic toneFlip;
    logic stepAdvance;
  } cadStrobeT;

  // ring positions within a 16-step group of the double-ring bank
  localparam int GROUP_LEN = 16;
  localparam logic [GROUP_LEN-1:0] DOUBLE_MASK = 16'b0000_0000_0001_1011;
  // number of leading ringing steps in the long-ring bank
  localparam int LONG_RING_STEPS = 20;

  function automatic logic patternBit(input int bank, input int idx);
    if (bank == 0) return DOUBLE_MASK[idx % GROUP_LEN];
    else           return (idx < LONG_RING_STEPS);
  endfunction

endpackage

// File: rtl/ringCtrl.sv
module ringCtrl
  import ringCadencePkg::*;
#(
  parameter int BASE_DIV = 2,
  parameter int STEP_DIV = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tickIn,
  output cadStrobeT strobes
);
  localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int SW = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(BASE_DIV - 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_DIV - 1);

  logic [BW-1:0] baseCnt;
  logic [SW-1:0] stepCnt;
  logic          toneHigh;
  logic          toneFlip;
  logic          toneFall;

  assign toneFlip = tickIn && (baseCnt == BASE_LAST);
  assign toneFall = toneFlip && toneHigh;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseCnt  <= '0;
      stepCnt  <= '0;
      toneHigh <= 1'b0;
    end else if (tickIn) begin
      if (toneFlip) begin
        baseCnt  <= '0;
        toneHigh <= ~toneHigh;
        if (toneFall) begin
          stepCnt <= (stepCnt == STEP_LAST) ? '0 : stepCnt + 1'b1;
        end
      end else begin
        baseCnt <= baseCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.toneFlip    = toneFlip;
    strobes.stepAdvance = toneFall && (stepCnt == STEP_LAST);
  end

endmodule

// File: rtl/ringPath.sv
module ringPath
  import ringCadencePkg::*;
#(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  cadStrobeT         strobes,
  input  logic              bankSel,
  output logic              toneOut,
  output logic              gateOut,
  output logic              ringOut,
  output logic [STEP_W-1:0] stepIdx
);
  localparam int DEPTH = 1 << STEP_W;

  logic [2*DEPTH-1:0] tableBits;
  logic               toneQ;
  logic [STEP_W-1:0]  stepQ;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      assign tableBits[b*DEPTH + i] = patternBit(b, i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      toneQ <= 1'b0;
      stepQ <= '0;
    end else begin
      if (strobes.toneFlip)    toneQ <= ~toneQ;
      if (strobes.stepAdvance) stepQ <= stepQ + 1'b1;
    end
  end

  assign toneOut = toneQ;
  assign gateOut = tableBits[{bankSel, stepQ}];
  assign ringOut = toneQ & gateOut;
  assign stepIdx = stepQ;

endmodule

// File: rtl/ringCadenceTop.sv
module ringCadenceTop
  import ringCadencePkg::*;
#(
  parameter int BASE_DIV = 2,
  parameter int STEP_DIV = 5,
  parameter int STEP_W   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tickIn,
  input  logic bankSel,
  output logic toneOut,
  output logic gateOut,
  output logic ringOut
);
  cadStrobeT         strobes;
  logic [STEP_W-1:0] stepIdx;

  ringCtrl #(.BASE_DIV(BASE_DIV), .STEP_DIV(STEP_DIV)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .tickIn  (tickIn),
    .strobes (strobes)
  );

  ringPath #(.STEP_W(STEP_W)) u_path (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .bankSel (bankSel),
    .toneOut (toneOut),
    .gateOut (gateOut),
    .ringOut (ringOut),
    .stepIdx (stepIdx)
  );

endmodule

// File: rtl/ringCadenceChk.sv
module ringCadenceChk #(
  parameter int STEP_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              tickIn,
  input logic              bankSel,
  input logic              toneOut,
  input logic              gateOut,
  input logic [STEP_W-1:0] stepIdx
);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (stepIdx == '0) && !toneOut);

  p_tone_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(toneOut) |-> $past(tickIn));

  p_step_on_tone_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(stepIdx) |-> $fell(toneOut));

  p_double_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (!bankSel && (stepIdx[3:0] == 4'd2 || stepIdx[3:0] > 4'd4)) |-> !gateOut);

  p_long_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (bankSel && stepIdx >= STEP_W'(20)) |-> !gateOut);

  p_step_plus_one_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(stepIdx) |-> stepIdx == STEP_W'($past(stepIdx) + 1));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !tickIn |=> $stable(stepIdx) && $stable(toneOut));

endmodule

bind ringCadenceTop ringCadenceChk #(.STEP_W(STEP_W)) u_chk (.*);

// File: tb/ringCadenceTop_bench.sv
`timescale 1ns/100ps
module ringCadenceTop_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickIn = 1'b0;
  logic bankSel = 1'b0;
  logic toneOut, gateOut, ringOut;

  always #2.5 clk = ~clk;

  ringCadenceTop u_ringCadenceTop (
    .clk(clk), .rst(rst), .tickIn(tickIn), .bankSel(bankSel),
    .toneOut(toneOut), .gateOut(gateOut), .ringOut(ringOut)
  );

  typedef struct {
    logic  tone;
    logic  gate;
    logic  ring;
    string tag;
  } expT;

  expT q[$];
  int  ticks = 0;
  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  // spec model of the pattern: R4 double ring, R5 long ring
  function automatic logic modelGate(input logic bank, input int step);
    int pos;
    if (!bank) begin
      pos = step % 16;
      return (pos == 0 || pos == 1 || pos == 3 || pos == 4);
    end
    return (step < 20);
  endfunction

  // driver: applies one cycle of stimulus and queues what must follow it
  task automatic drive(input logic t, input logic b);
    expT   e;
    string tag;
    int    step;
    @(negedge clk);
    tag = "";
    if (b != bankSel) tag = "R6";
    bankSel = b;
    tickIn  = t;
    if (t) ticks++;
    step = (ticks / 20) % 64;
    if (tag == "") begin
      if (!t)                               tag = "R9";
      else if (ticks % 1280 == 0)           tag = "R8";
      else if (ticks % 20 == 0)             tag = "R3";
      else if (b)                           tag = "R5";
      else                                  tag = "R4";
    end
    e.tone = ((ticks / 2) % 2) == 1;
    e.gate = modelGate(b, step);
    e.ring = e.tone & e.gate;
    e.tag  = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compares one cycle after the edge that consumed the stimulus
  always begin
    expT e;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      tests++;
      if (toneOut !== e.tone || gateOut !== e.gate || ringOut !== e.ring) begin
        fails++;
        if (toneOut !== e.tone)
          $display("FAIL %s R2 tone tick=%0d actual=%b expected=%b", e.tag, ticks, toneOut, e.tone);
        if (gateOut !== e.gate)
          $display("FAIL %s gate tick=%0d actual=%b expected=%b", e.tag, ticks, gateOut, e.gate);
        if (ringOut !== e.ring)
          $display("FAIL %s R7 ring tick=%0d actual=%b expected=%b", e.tag, ticks, ringOut, e.ring);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, bank 0 step 0 rings, tone low
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b0);

    // double-ring bank across a full wrap, with idle gaps (R4, R3, R8, R9)
    for (int i = 0; i < 1300; i++) begin
      drive(1'b1, 1'b0);
      if (i % 7 == 3) drive(1'b0, 1'b0);
    end

    // switch to long-ring bank mid-step (R6), run past its wrap (R5, R8)
    drive(1'b0, 1'b1);
    for (int i = 0; i < 1320; i++) begin
      drive(1'b1, 1'b1);
      if (i % 11 == 5) drive(1'b0, 1'b1);
    end

    // switch back while a step is in progress (R6)
    drive(1'b1, 1'b0);
    for (int i = 0; i < 60; i++) drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);

    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #2;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule